// File: doc/BRIEF.md
# Radix Page Table Walker

This block translates an effective address by walking a radix tree of 64-bit entries held in memory. A walk starts from a root directory base, a root index width and a total translated width. At every level the block picks an index out of the effective address, reads one entry, and then does one of three things:

- it faults;
- it descends to the next directory that the entry names;
- it stops at a leaf.

Each directory entry gives its own next-level index width, so both the depth of the tree and the final page size can differ from one walk to the next.

At a leaf, the block hands the entry to an external permission checker through a request/acknowledge pair. If the checker allows the access, the block reports four results:

- the real address;
- the page size as log2 bytes;
- the leaf entry;
- the memory address of the leaf entry, so that a later reference/change write-back can target it.

Any fault is reported as a cause code instead. Memory is reached through a request/grant read port with one read outstanding at a time.

Top module: `radix_walker`

## Requirements
- R1: After reset, mem_req, perm_req and done are low and fault_cause is 0.
- R2: The entry read for a level is at base + ((EA >> (rem − w)) & (2^w − 1)) × 8. Here w is the index width of that level and rem is the remaining width, which starts at total_size.
- R3: An entry whose bit 63 (valid) is 0 ends the walk with fault_cause 1 (no entry).
- R4: The walk ends with fault_cause 2 (bad configuration) and no further read when a level index width is below 5, or is larger than the remaining width. The width comes from root_nls for the root level, or from bits 60:56 of a directory entry.
- R5: An entry with bit 63 set and bit 62 (leaf) clear is a directory entry. It reduces the remaining width by the current level width, and the next level uses base = {entry[55:3], 3'b000} and width = entry[60:56].
- R6: On a leaf entry (bits 63 and 62 set), let r be the remaining width after subtracting that level's width. Then real_addr is entry[55:0] with bits below r cleared, ORed with EA bits below r; page_log2 is r; leaf_pte is the entry; and leaf_addr is the address it was read from.
- R7: A walk that still has a directory entry after 8 reads ends with fault_cause 2, after exactly 8 reads.
- R8: On a leaf, perm_req is held with perm_pte equal to the leaf entry until perm_ack. If perm_deny is set with the acknowledge, the walk ends with fault_cause 3; otherwise it ends with fault_cause 0.
- R9: mem_req is held with a stable mem_addr until mem_gnt, and no new request is made until the data of the granted read has returned.
- R10: done is a one-cycle pulse that ends every walk, and a start pulse that arrives during a walk has no effect on it.
- R11: EA bits at or above total_size do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| ea | input | EA_W | Effective address |
| root_base | input | PA_W | Root directory base address |
| root_nls | input | NLS_W | Root level index width |
| total_size | input | RS_W | Total translated width in bits |
| mem_req | output | 1 | Entry read request |
| mem_addr | output | PA_W | Entry read address |
| mem_gnt | input | 1 | Read request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Entry read data |
| perm_req | output | 1 | Permission check request |
| perm_pte | output | 64 | Leaf entry presented to the checker |
| perm_ack | input | 1 | Permission check complete |
| perm_deny | input | 1 | Access refused (valid with perm_ack) |
| done | output | 1 | Walk finished (one cycle) |
| fault_cause | output | 2 | 0 ok, 1 no entry, 2 bad configuration, 3 protection |
| real_addr | output | PA_W | Translated address |
| page_log2 | output | RS_W | Page size as log2 bytes |
| leaf_pte | output | 64 | Leaf entry |
| leaf_addr | output | PA_W | Address the leaf entry was read from |

## Verification
The assertions rely on the environment following the two handshakes. The memory model returns exactly one data beat on the cycle after each grant, and never without a grant. The permission checker raises perm_ack for a single cycle, and only in answer to perm_req. The bench models both sides in exactly that way. Its grant can be withheld for several cycles, which tests the hold of the request and address under back-pressure. Root bases and directory bases are kept 8-byte aligned so that entry addresses fall on entry boundaries.

// File: rtl/radix_walker.sv
module radix_walker #(
  parameter int EA_W       = 64,
  parameter int PA_W       = 56,
  parameter int NLS_W      = 5,
  parameter int MAX_LEVELS = 8,
  parameter int MIN_NLS    = 5,
  localparam int RS_W      = $clog2(EA_W + 1),
  localparam int LV_W      = $clog2(MAX_LEVELS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [EA_W-1:0]  ea,
  input  logic [PA_W-1:0]  root_base,
  input  logic [NLS_W-1:0] root_nls,
  input  logic [RS_W-1:0]  total_size,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_gnt,
  input  logic             mem_rvalid,
  input  logic [63:0]      mem_rdata,
  output logic             perm_req,
  output logic [63:0]      perm_pte,
  input  logic             perm_ack,
  input  logic             perm_deny,
  output logic             done,
  output logic [1:0]       fault_cause,
  output logic [PA_W-1:0]  real_addr,
  output logic [RS_W-1:0]  page_log2,
  output logic [63:0]      leaf_pte,
  output logic [PA_W-1:0]  leaf_addr
);

  localparam int VBIT = 63;
  localparam int LBIT = 62;
  localparam int NLSB = 56;
  localparam logic [1:0] C_OK = 2'd0, C_NOENT = 2'd1, C_BADCFG = 2'd2, C_PROT = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_EVAL, S_PERM, S_DONE, S_FAULT} st_t;

  st_t              st;
  logic [EA_W-1:0]  ea_q;
  logic [PA_W-1:0]  base_q;
  logic [NLS_W-1:0] nls_q;
  logic [RS_W-1:0]  rem_q;
  logic [LV_W-1:0]  lvl_q;
  logic [63:0]      ent_q;

  logic [RS_W-1:0]  shift_w, rem_nxt;
  logic [PA_W-1:0]  addr_w, ra_w;
  logic [EA_W-1:0]  pmask;
  logic [NLS_W-1:0] ent_nls;
  logic             root_bad, next_bad;

  assign shift_w = rem_q - RS_W'(nls_q);
  assign addr_w  = base_q + PA_W'(((ea_q >> shift_w) &
                   ((EA_W'(1) << nls_q) - EA_W'(1))) << 3);
  assign rem_nxt = rem_q - RS_W'(nls_q);
  assign pmask   = (EA_W'(1) << rem_nxt) - EA_W'(1);
  assign ra_w    = PA_W'(({{(EA_W-PA_W){1'b0}}, ent_q[PA_W-1:0]} & ~pmask) | (ea_q & pmask));
  assign ent_nls = ent_q[NLSB +: NLS_W];

  assign root_bad = (root_nls < NLS_W'(MIN_NLS)) || (RS_W'(root_nls) > total_size);
  assign next_bad = (ent_nls < NLS_W'(MIN_NLS)) || (RS_W'(ent_nls) > rem_nxt) ||
                    (lvl_q == LV_W'(MAX_LEVELS));

  assign mem_req  = (st == S_ISSUE);
  assign mem_addr = addr_w;
  assign perm_req = (st == S_PERM);
  assign perm_pte = leaf_pte;
  assign done     = (st == S_DONE) || (st == S_FAULT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      ea_q        <= '0;
      base_q      <= '0;
      nls_q       <= '0;
      rem_q       <= '0;
      lvl_q       <= '0;
      ent_q       <= '0;
      fault_cause <= C_OK;
      real_addr   <= '0;
      page_log2   <= '0;
      leaf_pte    <= '0;
      leaf_addr   <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          ea_q        <= ea;
          base_q      <= root_base;
          nls_q       <= root_nls;
          rem_q       <= total_size;
          lvl_q       <= '0;
          fault_cause <= root_bad ? C_BADCFG : C_OK;
          st          <= root_bad ? S_FAULT : S_ISSUE;
        end
        S_ISSUE: if (mem_gnt) st <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
          ent_q <= mem_rdata;
          lvl_q <= lvl_q + LV_W'(1);
          st    <= S_EVAL;
        end
        S_EVAL: begin
          if (!ent_q[VBIT]) begin
            fault_cause <= C_NOENT;
            st          <= S_FAULT;
          end else if (ent_q[LBIT]) begin
            real_addr <= ra_w;
            page_log2 <= rem_nxt;
            leaf_pte  <= ent_q;
            leaf_addr <= addr_w;
            st        <= S_PERM;
          end else if (next_bad) begin
            fault_cause <= C_BADCFG;
            st          <= S_FAULT;
          end else begin
            base_q <= {ent_q[PA_W-1:3], 3'b000};
            nls_q  <= ent_nls;
            rem_q  <= rem_nxt;
            st     <= S_ISSUE;
          end
        end
        S_PERM: if (perm_ack) begin
          fault_cause <= perm_deny ? C_PROT : C_OK;
          st          <= perm_deny ? S_FAULT : S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/radix_walker_chk.sv
module radix_walker_chk #(
  parameter int PA_W       = 56,
  parameter int MAX_LEVELS = 8,
  localparam int CW        = $clog2(MAX_LEVELS + 2) + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            mem_req,
  input logic            mem_gnt,
  input logic [PA_W-1:0] mem_addr,
  input logic            perm_req,
  input logic            perm_ack,
  input logic [63:0]     perm_pte,
  input logic            done
);

  logic          busy_c;
  logic [CW-1:0] reads_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_c  <= 1'b0;
      reads_c <= '0;
    end else if (start && !busy_c) begin
      busy_c  <= 1'b1;
      reads_c <= '0;
    end else begin
      if (done) busy_c <= 1'b0;
      if (mem_req && mem_gnt) reads_c <= reads_c + CW'(1);
    end
  end

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));

  p_one_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_gnt |=> !mem_req);

  p_perm_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    perm_req && !perm_ack |=> perm_req && $stable(perm_pte));

  p_perm_leaf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    perm_req |-> perm_pte[63] && perm_pte[62]);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req && !perm_req);

  p_level_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reads_c <= CW'(MAX_LEVELS));

endmodule

bind radix_walker radix_walker_chk #(.PA_W(PA_W), .MAX_LEVELS(MAX_LEVELS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mem_req(mem_req), .mem_gnt(mem_gnt),
  .mem_addr(mem_addr), .perm_req(perm_req), .perm_ack(perm_ack), .perm_pte(perm_pte),
  .done(done)
);

// File: tb/sim_radix_walker.sv
`timescale 1ns/1ps
module sim_radix_walker;
  localparam int EA_W = 64, PA_W = 56, NLS_W = 5, RS_W = 7, NV = 10;

  logic clk = 0, rst_n = 0, start = 0;
  logic [EA_W-1:0] ea = '0;
  logic [PA_W-1:0] root_base = '0;
  logic [NLS_W-1:0] root_nls = '0;
  logic [RS_W-1:0] total_size = '0;
  logic mem_req, mem_gnt = 1, mem_rvalid = 0, perm_req, perm_ack = 0, perm_deny = 0, done;
  logic [PA_W-1:0] mem_addr, real_addr, leaf_addr;
  logic [63:0] mem_rdata = '0, perm_pte, leaf_pte;
  logic [1:0] fault_cause;
  logic [RS_W-1:0] page_log2;
  int checks = 0, fails = 0, rd_cnt = 0;

  always #2 clk = ~clk;

  radix_walker u0 (.*);

  function automatic logic [63:0] mem_at(input logic [PA_W-1:0] a);
    case (a)
      56'h1000: return 64'h8500_0000_0000_2000;
      56'h1008: return 64'hC000_0000_005A_0000;
      56'h1010: return 64'h8A00_0000_0000_3000;
      56'h1018: return 64'h9000_0000_0000_5000;
      56'h1020: return 64'hC000_0000_0060_0002;
      56'h2008: return 64'hC000_0000_0012_3400;
      56'h2018: return 64'h8400_0000_0000_6000;
      56'h3018: return 64'hC000_0000_0077_7000;
      56'h4000: return 64'h8500_0000_0000_4000;
      default:  return 64'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req && mem_gnt) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= mem_at(mem_addr);
      rd_cnt     <= rd_cnt + 1;
    end
    perm_ack  <= perm_req && !perm_ack;
    perm_deny <= perm_pte[1];
  end

  localparam logic [63:0] V_EA [NV] = '{64'h523, 64'h9234, 64'h1007F, 64'h800, 64'hC00,
    64'h18000, 64'h20000, 64'h0, 64'h0, 64'hFFFF_FFFF_FFF0_0523};
  localparam logic [55:0] V_BASE [NV] = '{56'h1000, 56'h1000, 56'h1000, 56'h1000, 56'h1000,
    56'h1000, 56'h1000, 56'h4000, 56'h1000, 56'h1000};
  localparam logic [4:0] V_NLS [NV] = '{5, 5, 5, 5, 5, 5, 5, 5, 4, 5};
  localparam logic [6:0] V_TOT [NV] = '{20, 20, 20, 20, 20, 20, 20, 60, 20, 20};
  localparam logic [1:0] V_CAUSE [NV] = '{0, 0, 0, 1, 2, 2, 3, 2, 2, 0};
  localparam int V_READS [NV] = '{2, 1, 2, 2, 2, 1, 1, 8, 0, 2};
  localparam logic [55:0] V_RA [NV] = '{56'h123523, 56'h5A1234, 56'h77701F, 0, 0, 0, 0, 0, 0, 56'h123523};
  localparam logic [6:0] V_LOG [NV] = '{10, 15, 5, 0, 0, 0, 0, 0, 0, 10};
  localparam logic [55:0] V_LADDR [NV] = '{56'h2008, 56'h1008, 56'h3018, 0, 0, 0, 0, 0, 0, 56'h2008};
  localparam logic [63:0] V_PTE [NV] = '{64'hC000_0000_0012_3400, 64'hC000_0000_005A_0000,
    64'hC000_0000_0077_7000, 0, 0, 0, 0, 0, 0, 64'hC000_0000_0012_3400};
  localparam string V_REQ [NV] = '{"R6", "R6", "R5", "R3", "R4", "R4", "R8", "R7", "R4", "R11"};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 300; i++) begin
      if (done) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic launch(input logic [63:0] e, input logic [55:0] b, input logic [4:0] n, input logic [6:0] t);
    ea = e; root_base = b; root_nls = n; total_size = t; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    bit ok;
    int r0;
    repeat (3) @(negedge clk);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 perm_req", perm_req, 0);
    chk("R1 done", done, 0);
    chk("R1 cause", fault_cause, 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      r0 = rd_cnt;
      launch(V_EA[v], V_BASE[v], V_NLS[v], V_TOT[v]);
      wait_done(ok);
      chk({V_REQ[v], " finished"}, ok, 1);
      chk({V_REQ[v], " cause"}, fault_cause, V_CAUSE[v]);
      chk({V_REQ[v], " reads (R2)"}, rd_cnt - r0, V_READS[v]);
      if (V_CAUSE[v] == 0) begin
        chk({V_REQ[v], " real_addr"}, real_addr, V_RA[v]);
        chk({V_REQ[v], " page_log2"}, page_log2, V_LOG[v]);
        chk({V_REQ[v], " leaf_addr"}, leaf_addr, V_LADDR[v]);
        chk({V_REQ[v], " leaf_pte"}, leaf_pte, V_PTE[v]);
      end
      @(negedge clk);
      chk("R10 done pulse", done, 0);
      @(negedge clk);
    end

    // R9 grant stall and R10 start ignored while busy
    mem_gnt = 0;
    r0 = rd_cnt;
    launch(64'h523, 56'h1000, 5, 20);
    for (int k = 0; k < 4; k++) begin
      chk("R9 req held", mem_req, 1);
      chk("R2 root entry addr", mem_addr, 56'h1000);
      ea = 64'h9234; start = 1;
      @(negedge clk);
    end
    start = 0;
    mem_gnt = 1;
    wait_done(ok);
    chk("R10 finished", ok, 1);
    chk("R10 busy start ignored", real_addr, 56'h123523);
    chk("R9 reads", rd_cnt - r0, 2);
    @(negedge clk);
    chk("R10 no second walk", mem_req, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule